// File: doc/BRIEF.md
# UART Modem Control Register with Diagnostic Loopback

This block holds the modem control byte of one serial channel and sits between the channel's serial engines and its device pins. In normal operation it drives the active-low handshake outputs (data-terminal-ready, request-to-send, and the auxiliary output OP2) from control bits. It hands the pin-level receive line and the modem inputs to the receiver and the modem status logic, and it passes the transmit stream out to the pin. One control bit also enables the channel's interrupt output. When that bit is clear, the interrupt line is left floating.

A further control bit selects a local diagnostic loopback. The external pins are then isolated. The transmit stream returns straight into the receive path, and the transmit pin rests at its idle high level. The four modem status inputs are taken from the low control bits, so software can provoke modem-status interrupts without any cable. The handshake outputs fall back to their inactive high level while loopback is on. The interrupt-output enable keeps working, so the interrupts of the channel are still delivered.

The register is written through a byte-wide strobe port and can be read back at any time. The routing that follows the register is purely combinational.

Top module: `mctl_top`

## Requirements
- R1: After synchronous reset the control byte reads 0x00. The pins `dtr_n_pin`, `rts_n_pin` and `op2_n_pin` are 1, and `irq_oe` is 0.
- R2: With loopback off, `dtr_n_pin` is the inverse of control bit 0.
- R3: With loopback off, `rts_n_pin` is the inverse of control bit 1.
- R4: With loopback off, control bit 3 at 1 gives `irq_oe`=1 and `op2_n_pin`=0. Bit 3 at 0 gives `irq_oe`=0 and `op2_n_pin`=1.
- R5: Bits [7:5] of the control byte always read 0, whatever value was written to them.
- R6: With loopback off, `rx_ser` equals `rx_pin` and `tx_pin` equals `tx_ser`. Each modem status output is the inverse of its active-low pin: `msr_cts`, `msr_dsr`, `msr_dcd` and `msr_ri` take `cts_n_pin`, `dsr_n_pin`, `dcd_n_pin` and `ri_n_pin` respectively.
- R7: With control bit 4 (loopback) at 1, `rx_ser` equals `tx_ser` and `tx_pin` is held at 1. `rx_pin` has no effect.
- R8: With loopback on, the modem status outputs come from the control byte: `msr_dsr` from bit 0, `msr_cts` from bit 1, `msr_ri` from bit 2 and `msr_dcd` from bit 3. The four modem pins have no effect.
- R9: With loopback on, `dtr_n_pin`, `rts_n_pin` and `op2_n_pin` are held at 1.
- R10: With loopback on, `irq_oe` still equals control bit 3.
- R11: A write with `wr_en`=1 takes effect at the next rising clock edge. With `wr_en`=0 the control byte holds, and `wr_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read-back |
| tx_ser | input | 1 | Serial stream from the transmitter |
| rx_ser | output | 1 | Serial stream to the receiver |
| tx_pin | output | 1 | Transmit pin |
| rx_pin | input | 1 | Receive pin |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low |
| ri_n_pin | input | 1 | Ring-indicator pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| dtr_n_pin | output | 1 | Data-terminal-ready pin, active low |
| op2_n_pin | output | 1 | Auxiliary output 2, active low |
| irq_oe | output | 1 | Interrupt output enable (0 = float the line) |
| msr_cts | output | 1 | Clear-to-send status to the modem status logic |
| msr_dsr | output | 1 | Data-set-ready status to the modem status logic |
| msr_dcd | output | 1 | Carrier-detect status to the modem status logic |
| msr_ri | output | 1 | Ring-indicator status to the modem status logic |

## Verification
A control write that switches loopback on or off can land in the same cycle in which the transmit stream and the modem pins change. After the edge, both the routing and the handshake outputs must reflect the new mode.

The bench provokes this by driving a fresh serial bit and fresh pin levels together with the write. It then compares every output, one requirement per field, against a model of the mode that applies after the edge. A second step holds the mode and inverts the pins, so that any stale path that still leaks pin values is exposed.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    localparam int CTRL_W = 8;
    localparam int RSVD_W = 3;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              loop;
        logic              out2;
        logic              out1;
        logic              rts;
        logic              dtr;
    } ctrl_t;

    typedef struct packed {
        logic cts;
        logic dsr;
        logic dcd;
        logic ri;
    } mstat_t;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] raw);
        ctrl_t c;
        c      = ctrl_t'(raw);
        c.rsvd = '0;
        return c;
    endfunction

    function automatic mstat_t from_pins(input logic cts_n, input logic dsr_n,
                                         input logic dcd_n, input logic ri_n);
        mstat_t s;
        s.cts = ~cts_n;
        s.dsr = ~dsr_n;
        s.dcd = ~dcd_n;
        s.ri  = ~ri_n;
        return s;
    endfunction

    function automatic mstat_t from_ctrl(input logic dtr, input logic rts,
                                         input logic out1, input logic out2);
        mstat_t s;
        s.cts = rts;
        s.dsr = dtr;
        s.dcd = out2;
        s.ri  = out1;
        return s;
    endfunction

endpackage

// File: rtl/mctl_reg.sv
module mctl_reg
    import mctl_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output ctrl_t        q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= to_ctrl(wr_data);
    end

    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        q.rsvd == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/mctl_route.sv
module mctl_route
    import mctl_pkg::*;
(
    input  logic   loop,
    input  logic   dtr,
    input  logic   rts,
    input  logic   out1,
    input  logic   out2,
    input  logic   tx_ser,
    input  logic   rx_pin,
    input  logic   cts_n_pin,
    input  logic   dsr_n_pin,
    input  logic   dcd_n_pin,
    input  logic   ri_n_pin,
    output logic   rx_ser,
    output logic   tx_pin,
    output logic   rts_n_pin,
    output logic   dtr_n_pin,
    output logic   op2_n_pin,
    output logic   irq_oe,
    output mstat_t stat
);

    mstat_t pin_stat, reg_stat;

    always_comb begin
        pin_stat = from_pins(cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin);
        reg_stat = from_ctrl(dtr, rts, out1, out2);
        irq_oe   = out2;
        if (loop) begin
            rx_ser    = tx_ser;
            tx_pin    = 1'b1;
            rts_n_pin = 1'b1;
            dtr_n_pin = 1'b1;
            op2_n_pin = 1'b1;
            stat      = reg_stat;
        end else begin
            rx_ser    = rx_pin;
            tx_pin    = tx_ser;
            rts_n_pin = ~rts;
            dtr_n_pin = ~dtr;
            op2_n_pin = ~out2;
            stat      = pin_stat;
        end
    end

    always_comb begin
        a_r9_pins_idle: assert (!loop || (rts_n_pin && dtr_n_pin && op2_n_pin));
    end

endmodule

// File: rtl/mctl_top.sv
module mctl_top
    import mctl_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         tx_ser,
    output logic         rx_ser,
    output logic         tx_pin,
    input  logic         rx_pin,
    input  logic         cts_n_pin,
    input  logic         dsr_n_pin,
    input  logic         dcd_n_pin,
    input  logic         ri_n_pin,
    output logic         rts_n_pin,
    output logic         dtr_n_pin,
    output logic         op2_n_pin,
    output logic         irq_oe,
    output logic         msr_cts,
    output logic         msr_dsr,
    output logic         msr_dcd,
    output logic         msr_ri
);

    ctrl_t  ctrl;
    mstat_t stat;

    mctl_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (ctrl)
    );

    mctl_route u_route (
        .loop      (ctrl.loop),
        .dtr       (ctrl.dtr),
        .rts       (ctrl.rts),
        .out1      (ctrl.out1),
        .out2      (ctrl.out2),
        .tx_ser    (tx_ser),
        .rx_pin    (rx_pin),
        .cts_n_pin (cts_n_pin),
        .dsr_n_pin (dsr_n_pin),
        .dcd_n_pin (dcd_n_pin),
        .ri_n_pin  (ri_n_pin),
        .rx_ser    (rx_ser),
        .tx_pin    (tx_pin),
        .rts_n_pin (rts_n_pin),
        .dtr_n_pin (dtr_n_pin),
        .op2_n_pin (op2_n_pin),
        .irq_oe    (irq_oe),
        .stat      (stat)
    );

    assign rd_data = W'(ctrl);
    assign msr_cts = stat.cts;
    assign msr_dsr = stat.dsr;
    assign msr_dcd = stat.dcd;
    assign msr_ri  = stat.ri;

    a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));

    a_r7_loop_route: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (tx_pin && rx_ser == tx_ser));

    a_r8_loop_status: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (msr_dsr == rd_data[0] && msr_cts == rd_data[1] &&
                        msr_ri == rd_data[2] && msr_dcd == rd_data[3]));

    a_r10_irq_enable: assert property (@(posedge clk) disable iff (rst)
        irq_oe == rd_data[3]);

    a_r6_normal_route: assert property (@(posedge clk) disable iff (rst)
        !rd_data[4] |-> (tx_pin == tx_ser && rx_ser == rx_pin &&
                         msr_cts == !cts_n_pin && msr_ri == !ri_n_pin));

endmodule

// File: tb/test_mctl_top.sv
module test_mctl_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       tx_ser, rx_ser, tx_pin, rx_pin;
    logic       cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin;
    logic       rts_n_pin, dtr_n_pin, op2_n_pin, irq_oe;
    logic       msr_cts, msr_dsr, msr_dcd, msr_ri;

    always #2 clk = ~clk;

    mctl_top i_mctl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_ser(tx_ser), .rx_ser(rx_ser), .tx_pin(tx_pin), .rx_pin(rx_pin),
        .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .dcd_n_pin(dcd_n_pin),
        .ri_n_pin(ri_n_pin), .rts_n_pin(rts_n_pin), .dtr_n_pin(dtr_n_pin),
        .op2_n_pin(op2_n_pin), .irq_oe(irq_oe), .msr_cts(msr_cts),
        .msr_dsr(msr_dsr), .msr_dcd(msr_dcd), .msr_ri(msr_ri)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       tx, rx, rts_n, dtr_n, op2_n, oe, cts, dsr, dcd, ri;
    } exp_t;

    exp_t       sb_q[$];
    event       sample_ev;
    int         n_vec  = 0;
    int         n_miss = 0;
    logic [7:0] model  = 8'h00;

    task automatic check1(input string tag, input string fld,
                          input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check1(e.tag, "rd_data",   rd_data,   e.rd);
                check1(e.tag, "tx_pin",    {7'b0, tx_pin},    {7'b0, e.tx});
                check1(e.tag, "rx_ser",    {7'b0, rx_ser},    {7'b0, e.rx});
                check1(e.tag, "rts_n_pin", {7'b0, rts_n_pin}, {7'b0, e.rts_n});
                check1(e.tag, "dtr_n_pin", {7'b0, dtr_n_pin}, {7'b0, e.dtr_n});
                check1(e.tag, "op2_n_pin", {7'b0, op2_n_pin}, {7'b0, e.op2_n});
                check1(e.tag, "irq_oe",    {7'b0, irq_oe},    {7'b0, e.oe});
                check1(e.tag, "msr_cts",   {7'b0, msr_cts},   {7'b0, e.cts});
                check1(e.tag, "msr_dsr",   {7'b0, msr_dsr},   {7'b0, e.dsr});
                check1(e.tag, "msr_dcd",   {7'b0, msr_dcd},   {7'b0, e.dcd});
                check1(e.tag, "msr_ri",    {7'b0, msr_ri},    {7'b0, e.ri});
            end
        end
    end

    // driver: applies one vector at a falling edge and predicts the result
    task automatic apply(input string tag, input logic we, input logic [7:0] d,
                         input logic tx, input logic rx, input logic [3:0] pins_n);
        exp_t e;
        @(negedge clk);
        wr_en     = we;
        wr_data   = d;
        tx_ser    = tx;
        rx_pin    = rx;
        cts_n_pin = pins_n[3];
        dsr_n_pin = pins_n[2];
        dcd_n_pin = pins_n[1];
        ri_n_pin  = pins_n[0];
        @(posedge clk);
        if (we) model = {3'b000, d[4:0]};
        e.tag = tag;
        e.rd  = model;
        e.oe  = model[3];
        if (model[4]) begin
            e.tx = 1'b1;  e.rx = tx;
            e.rts_n = 1'b1; e.dtr_n = 1'b1; e.op2_n = 1'b1;
            e.dsr = model[0]; e.cts = model[1]; e.ri = model[2]; e.dcd = model[3];
        end else begin
            e.tx = tx;  e.rx = rx;
            e.rts_n = ~model[1]; e.dtr_n = ~model[0]; e.op2_n = ~model[3];
            e.cts = ~pins_n[3]; e.dsr = ~pins_n[2]; e.dcd = ~pins_n[1]; e.ri = ~pins_n[0];
        end
        #1;
        sb_q.push_back(e);
        ->sample_ev;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        tx_ser = 1'b0; rx_pin = 1'b1;
        cts_n_pin = 1'b1; dsr_n_pin = 1'b1; dcd_n_pin = 1'b1; ri_n_pin = 1'b1;
        repeat (3) @(posedge clk);
        apply("R1 reset", 1'b0, 8'hFF, 1'b0, 1'b1, 4'b1111);
        @(negedge clk);
        rst = 1'b0;
        apply("R1 idle",            1'b0, 8'h00, 1'b0, 1'b1, 4'b1111);
        apply("R2 dtr",             1'b1, 8'h01, 1'b1, 1'b0, 4'b1111);
        apply("R3 rts",             1'b1, 8'h02, 1'b0, 1'b1, 4'b0101);
        apply("R4 oe",              1'b1, 8'h08, 1'b1, 1'b1, 4'b1010);
        apply("R4 oe off",          1'b1, 8'h03, 1'b0, 1'b0, 4'b0000);
        apply("R5 reserved",        1'b1, 8'hE0, 1'b1, 1'b0, 4'b0110);
        apply("R6 pass",            1'b1, 8'h0B, 1'b1, 1'b0, 4'b0010);
        apply("R11 hold",           1'b0, 8'h1F, 1'b0, 1'b1, 4'b1101);
        apply("R7 loop on",         1'b1, 8'h10, 1'b1, 1'b0, 4'b0000);
        apply("R7 loop tx",         1'b0, 8'h00, 1'b0, 1'b1, 4'b1111);
        apply("R8 R9 R10 loop all", 1'b1, 8'hFF, 1'b1, 1'b0, 4'b1111);
        apply("R8 pins ignored",    1'b0, 8'h00, 1'b0, 1'b1, 4'b0000);
        apply("R8 pattern",         1'b1, 8'h15, 1'b1, 1'b1, 4'b0000);
        apply("R10 loop oe",        1'b1, 8'h1A, 1'b0, 1'b0, 4'b1001);
        apply("R6 loop off",        1'b1, 8'h0A, 1'b1, 1'b0, 4'b0110);
        apply("R11 hold normal",    1'b0, 8'h10, 1'b0, 1'b1, 4'b1001);
        apply("R1 reset again",     1'b0, 8'h00, 1'b1, 1'b1, 4'b1111);
        @(negedge clk);
        rst = 1'b1;
        model = 8'h00;
        apply("R1 reset again",     1'b0, 8'h00, 1'b1, 1'b1, 4'b1111);
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule